// File: doc/BRIEF.md
# Prioritised Interrupt Request Controller

This block gathers ten external interrupt request lines and turns them into one request for a pipelined processor core, together with an 8-bit number that tells the core which line it is serving. Each line is watched for a low-to-high transition. The transition sets a pending bit, so a request that is high for only one clock cycle is still kept. A line that stays high counts once.

A small state machine controls the hand-off. In `ST_IDLE` the block waits until at least one bit is pending and the core's disable input is low. It then records the lowest-numbered pending line and moves to `ST_OFFER`, where it drives the request output. The core takes the interrupt by raising its disable flag. That acceptance clears the pending bit of the offered line and moves the machine to `ST_SERVE`. The machine stays in `ST_SERVE` until the core drops the disable flag on return from interrupt, and then goes back to `ST_IDLE`.

The transitions are:
- idle to offer: something pending and disable low.
- offer to serve: disable seen high.
- serve to idle: disable seen low.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While reset is held, and on the cycle after it is released, `irq_req` is 0 and `irq_id` is 0.
- R2: Bit k-1 of `req_lines` is interrupt number k. A rising edge on a line sets its pending bit at the next clock edge, even when the line is high for a single cycle. When the block is idle with disable low, `irq_req` is high after the second rising clock edge that follows the line going high.
- R3: When several interrupts are pending, the lowest-numbered one is offered first. Whenever `irq_req` is high, `irq_id` holds that number, in the range 1 to 10.
- R4: In `ST_IDLE`, `irq_id` shows the lowest pending number, or 0 when nothing is pending, and `irq_req` is 0.
- R5: While `core_irq_off` is high, no new request is offered. When it falls with an interrupt pending, `irq_req` rises one clock edge later.
- R6: `core_irq_off` seen high at a clock edge while offering marks acceptance. At that edge the offered pending bit clears, and `irq_req` falls. `irq_id` keeps the serviced number until `core_irq_off` falls.
- R7: While offering and `core_irq_off` is low, `irq_req` and `irq_id` stay unchanged, even if a lower-numbered line becomes pending.
- R8: A further rising edge on a line that is already pending does not queue a second occurrence.
- R9: A rising edge on the offered line at the same clock edge as its acceptance leaves that line pending, so it is offered again.
- R10: A line held high for many cycles produces exactly one occurrence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_lines | input | 10 | Interrupt request lines; bit k-1 is interrupt k |
| core_irq_off | input | 1 | Interrupts-disabled flag from the core |
| irq_req | output | 1 | Request to the core |
| irq_id | output | 8 | Number of the offered, serviced or lowest pending interrupt; 0 if none |

## Verification
Every one of the 1023 non-empty combinations of simultaneous pulses is applied. The bench then checks that servicing drains the combination in strictly ascending order, with the correct idle number after each return. A wrong priority chain would give out a higher number first. A clear decoded with the wrong width or offset would drop a neighbour or leave a line that is offered forever.

Directed cases cover the following:
- a lower-numbered arrival during an offer, where a design without the freeze would switch the identifier under the core;
- a repeated edge on a pending line, where a counting design would serve it twice;
- a new edge coinciding with acceptance, where a design in which clear wins would lose the occurrence;
- a line held high, where a level-sensitive design would re-offer it endlessly.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OFFER = 2'd1,
        ST_SERVE = 2'd2
    } irq_state_e;

endpackage

// File: rtl/irq_line_latch.sv
module irq_line_latch #(
    parameter int NUM_LINES = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] lines,
    input  logic [NUM_LINES-1:0] clr_vec,
    output logic [NUM_LINES-1:0] pending
);

    logic [NUM_LINES-1:0] prev_q;

    genvar g;
    generate
        for (g = 0; g < NUM_LINES; g++) begin : g_line
            logic rise;
            assign rise = lines[g] & ~prev_q[g];

            always_ff @(posedge clk) begin
                if (rst) begin
                    prev_q[g]  <= 1'b0;
                    pending[g] <= 1'b0;
                end else begin
                    prev_q[g]  <= lines[g];
                    // a new edge wins over a clear on the same edge
                    pending[g] <= (pending[g] & ~clr_vec[g]) | rise;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
    parameter int NUM_LINES = 10,
    parameter int ID_W      = 8
) (
    input  logic [NUM_LINES-1:0] pending,
    output logic                 any,
    output logic [ID_W-1:0]      win_id
);

    always_comb begin
        win_id = '0;
        for (int k = NUM_LINES - 1; k >= 0; k--) begin
            if (pending[k]) begin
                win_id = ID_W'(k + 1);
            end
        end
        any = |pending;
    end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int NUM_LINES = 10,
    parameter int ID_W      = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] req_lines,
    input  logic                 core_irq_off,
    output logic                 irq_req,
    output logic [ID_W-1:0]      irq_id
);

    irq_state_e           state_q, state_d;
    logic [ID_W-1:0]      held_id_q;
    logic [NUM_LINES-1:0] pending;
    logic [NUM_LINES-1:0] clr_vec;
    logic                 any_pend;
    logic [ID_W-1:0]      win_id;
    logic                 accept;

    irq_line_latch #(.NUM_LINES(NUM_LINES)) u_latch (
        .clk     (clk),
        .rst     (rst),
        .lines   (req_lines),
        .clr_vec (clr_vec),
        .pending (pending)
    );

    irq_lowest_pick #(.NUM_LINES(NUM_LINES), .ID_W(ID_W)) u_pick (
        .pending (pending),
        .any     (any_pend),
        .win_id  (win_id)
    );

    assign accept = (state_q == ST_OFFER) && core_irq_off;

    genvar g;
    generate
        for (g = 0; g < NUM_LINES; g++) begin : g_clr
            assign clr_vec[g] = accept && (held_id_q == ID_W'(g + 1));
        end
    endgenerate

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (any_pend && !core_irq_off) state_d = ST_OFFER;
            ST_OFFER: if (core_irq_off)              state_d = ST_SERVE;
            ST_SERVE: if (!core_irq_off)             state_d = ST_IDLE;
            default:                                 state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            held_id_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && state_d == ST_OFFER) begin
                held_id_q <= win_id;
            end
        end
    end

    always_comb begin
        irq_req = 1'b0;
        irq_id  = '0;
        unique case (state_q)
            ST_IDLE:  irq_id = win_id;
            ST_OFFER: begin
                irq_req = 1'b1;
                irq_id  = held_id_q;
            end
            ST_SERVE: irq_id = held_id_q;
            default:  irq_id = '0;
        endcase
    end

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
    parameter int NUM_LINES = 10,
    parameter int ID_W      = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            core_irq_off,
    input logic            irq_req,
    input logic [ID_W-1:0] irq_id
);

    // R3
    id_range_chk: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (irq_id >= ID_W'(1) && irq_id <= ID_W'(NUM_LINES)));

    // R5
    hold_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!irq_req && core_irq_off) |=> !irq_req);

    // R6
    accept_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_req && core_irq_off) |=> (!irq_req && $stable(irq_id)));

    // R7
    offer_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_req && !core_irq_off) |=> (irq_req && $stable(irq_id)));

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.NUM_LINES(NUM_LINES), .ID_W(ID_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .core_irq_off (core_irq_off),
    .irq_req      (irq_req),
    .irq_id       (irq_id)
);

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;

    localparam int N = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] req_lines = '0;
    logic         core_irq_off = 1'b0;
    logic         irq_req;
    logic [7:0]   irq_id;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    irq_prio_ctrl u_dut (
        .clk          (clk),
        .rst          (rst),
        .req_lines    (req_lines),
        .core_irq_off (core_irq_off),
        .irq_req      (irq_req),
        .irq_id       (irq_id)
    );

    function automatic int lowest(input logic [N-1:0] m);
        for (int k = 0; k < N; k++) if (m[k]) return k + 1;
        return 0;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse(input logic [N-1:0] m);
        req_lines = m;
        tick(1);
        req_lines = '0;
    endtask

    // wait for an offer, check id, accept, return; then check idle id
    task automatic serve(input string req, input int exp_id, input int exp_next);
        int w = 0;
        while (!irq_req && w < 8) begin tick(1); w++; end
        chk({req, " offer"}, irq_req, 1);
        chk({req, " id"}, irq_id, exp_id);
        core_irq_off = 1'b1;
        tick(1);
        chk("R6 req drops", irq_req, 0);
        chk("R6 id held", irq_id, exp_id);
        core_irq_off = 1'b0;
        tick(1);
        chk("R4 idle id", irq_id, exp_next);
        chk("R4 idle req", irq_req, 0);
    endtask

    initial begin
        tick(2);
        chk("R1 req in reset", irq_req, 0);
        chk("R1 id in reset", irq_id, 0);
        rst = 1'b0;
        tick(1);
        chk("R1 req after reset", irq_req, 0);
        chk("R1 id after reset", irq_id, 0);

        // R2 exact timing of a one-cycle pulse
        pulse(10'b0000010000);
        chk("R2 not yet", irq_req, 0);
        chk("R2 idle id", irq_id, 5);
        tick(1);
        chk("R2 offer", irq_req, 1);
        serve("R2", 5, 0);

        // R3 exhaustive sweep of simultaneous pulse patterns
        for (int m = 1; m < (1 << N); m++) begin
            logic [N-1:0] rem;
            rem = N'(m);
            pulse(rem);
            while (rem != '0) begin
                int e;
                e = lowest(rem);
                rem[e-1] = 1'b0;
                serve("R3", e, lowest(rem));
            end
            tick(1);
            chk("R4 empty", irq_id, 0);
        end

        // R5 disable high holds off a new request
        core_irq_off = 1'b1;
        pulse(10'b0001000000);
        tick(3);
        chk("R5 held req", irq_req, 0);
        chk("R5 idle id", irq_id, 7);
        core_irq_off = 1'b0;
        tick(1);
        chk("R5 offer after fall", irq_req, 1);
        serve("R5", 7, 0);

        // R7 lower arrival during an offer does not change the offer
        pulse(10'b0000100000);
        tick(1);
        chk("R7 offer", irq_id, 6);
        pulse(10'b0000000010);
        tick(2);
        chk("R7 still 6", irq_id, 6);
        chk("R7 req", irq_req, 1);
        serve("R7", 6, 2);
        serve("R7", 2, 0);

        // R8 repeated edges on a pending line count once
        core_irq_off = 1'b1;
        pulse(10'b0000000100);
        tick(1);
        pulse(10'b0000000100);
        tick(1);
        pulse(10'b0000000100);
        core_irq_off = 1'b0;
        serve("R8", 3, 0);
        tick(4);
        chk("R8 no second", irq_req, 0);
        chk("R8 id empty", irq_id, 0);

        // R9 new edge coinciding with acceptance keeps the line pending
        pulse(10'b0000001000);
        tick(1);
        chk("R9 offer", irq_id, 4);
        req_lines = 10'b0000001000;
        core_irq_off = 1'b1;
        tick(1);
        req_lines = '0;
        chk("R9 accepted", irq_req, 0);
        core_irq_off = 1'b0;
        tick(1);
        chk("R9 still pending", irq_id, 4);
        serve("R9", 4, 0);

        // R10 a level held high is one occurrence
        req_lines = 10'b1000000000;
        tick(2);
        serve("R10", 10, 0);
        tick(5);
        chk("R10 no repeat", irq_req, 0);
        chk("R10 id", irq_id, 0);
        req_lines = '0;
        tick(2);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 190000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule